// File: doc/BRIEF.md
# Palettized LCD Pixel Unpacker

This block sits between a display frame-data buffer and the panel pixel pipeline. It accepts 64-bit display data words on a valid/ready stream and splits each word into pixels at a programmed depth. Depths of 1, 2, 4 and 8 bits per pixel are palette indices: each index selects a 16-bit entry in a 256-entry color table, and that entry is widened to 24-bit RGB. The 16 and 24 bits-per-pixel modes carry color directly and bypass the table.

The color table is a 128-word by 32-bit memory that holds two entries per word. It is loaded through a simple write port, one word per cycle. Pixels leave on a valid/ready stream as 24-bit RGB plus a flag that marks a table result. Depth, pixel order and panel type are sampled together with each data word, so a configuration change takes effect at a word boundary.

The control is a two-state machine. `ST_IDLE` waits for a data word with `in_ready` high; the transition idle-to-emit fires when a word is accepted. `ST_EMIT` issues one pixel per cycle into the output register whenever that register is empty or being drained; the transition emit-to-idle fires when the last pixel of the word is issued. Table reads take one cycle, and the output register is loaded at the same edge the read is launched, so the output valid matches the table latency.

Top module: `lcd_pixel_unpacker`

## Requirements
- R1: While reset is asserted and right after it is released, `in_ready` is 1 and `px_valid` is 0.
- R2: A table write with `pal_we`=1 stores `pal_wdata` at word `pal_waddr` in one cycle; entry 2k is bits 15:0 of word k and entry 2k+1 is bits 31:16. A palettized pixel with index n shows the current value of entry n, and a rewrite changes later pixels that use it.
- R3: `cfg_depth` codes are 0=1 bpp, 1=2 bpp, 2=4 bpp, 3=8 bpp, 4=16 bpp, 5=24 bpp; codes 6 and 7 act as 8 bpp. A word yields 64/bpp pixels, and 2 pixels in 24 bpp mode.
- R4: With `cfg_order`=0 (or 3), pixel i of a word is bits [i*bpp +: bpp].
- R5: With `cfg_order`=1, pixel i is bits [64-(i+1)*bpp +: bpp], so the first pixel comes from the most significant end.
- R6: With `cfg_order`=2 and bpp below 8, bytes are taken from least to most significant and pixels within a byte from its most significant end; at 8 and 16 bpp this order equals order 0.
- R7: A 16-bit color (table entry or 16 bpp pixel) with fields r[15:11], g[10:5], b[4:0] becomes RGB {r,r[4:2]}, {g,g[5:4]}, {b,b[4:2]} in `px_rgb`[23:16], [15:8], [7:0]. `px_pal` is 1 for depths 1 to 8 and 0 for 16 and 24 bpp.
- R8: With code 5 and `cfg_tft`=1, the two pixels come from bits 23:0 and 47:24 (in that order for orders 0, 2, 3 and reversed for order 1), and bits 63:48 are ignored. With `cfg_tft`=0, code 5 acts as 16 bpp.
- R9: While `px_valid`=1 and `px_ready`=0, the output holds: `px_valid` stays 1 and `px_rgb`, `px_pal` are unchanged; no pixel is lost or repeated.
- R10: A word is accepted only in `ST_IDLE`, which is entered once every pixel of the held word has been issued into the output register; `in_ready` is 0 for at least the cycle after an accept. Depth, order and panel type are captured at the accept, and changes during the word have no effect on its pixels.
- R11: `px_valid` is 1 two clock edges after an accepting edge, and while the machine is in `ST_EMIT` with an empty output register a pixel appears at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_depth | input | 3 | Pixel depth code, sampled at word accept |
| cfg_order | input | 2 | Pixel order code, sampled at word accept |
| cfg_tft | input | 1 | Panel is TFT; enables 24 bpp |
| pal_we | input | 1 | Color table write enable |
| pal_waddr | input | 7 | Color table word address |
| pal_wdata | input | 32 | Two table entries, high and low half |
| in_valid | input | 1 | Data word valid |
| in_data | input | 64 | Display data word |
| in_ready | output | 1 | Unpacker can take a word |
| px_valid | output | 1 | Pixel valid |
| px_ready | input | 1 | Pixel consumer ready |
| px_rgb | output | 24 | Pixel color, 8 bits each of R, G, B |
| px_pal | output | 1 | Pixel came from the color table |

## Verification
The bench drives every depth under each pixel order, including the mixed order at 1, 2 and 4 bpp, where a design that used plain bit order would emit the pixels of a byte mirrored. It checks table halves with odd and even indices, so swapped halves show as wrong colors, and 24 bpp words with junk in the top 16 bits, plus the same code without a TFT panel, where a wrong design would emit two pixels instead of four. Random back-pressure tests that the held pixel and the matching table data survive stalls, and a configuration change in the middle of a word shows whether the settings were latched at the accept or read live.

// File: rtl/pxu_pkg.sv
package pxu_pkg;

    typedef enum logic [2:0] {
        DEP_1  = 3'd0,
        DEP_2  = 3'd1,
        DEP_4  = 3'd2,
        DEP_8  = 3'd3,
        DEP_16 = 3'd4,
        DEP_24 = 3'd5
    } depth_e;

    typedef enum logic [1:0] {
        ORD_LE  = 2'd0,
        ORD_BE  = 2'd1,
        ORD_MIX = 2'd2,
        ORD_LE2 = 2'd3
    } order_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } ust_e;

    // Bits per pixel for a depth
    function automatic int bpp_of(depth_e d);
        case (d)
            DEP_1:   return 1;
            DEP_2:   return 2;
            DEP_4:   return 4;
            DEP_8:   return 8;
            DEP_16:  return 16;
            default: return 24;
        endcase
    endfunction

    // Index of the last pixel in a word of data_w bits
    function automatic int last_of(depth_e d, int data_w);
        if (d == DEP_24) return 1;
        return data_w / bpp_of(d) - 1;
    endfunction

endpackage

// File: rtl/pxu_palette_ram.sv
module pxu_palette_ram #(
    parameter int AW = 7,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Synchronous read with enable: data stays put while the reader stalls
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
        if (rd_en) begin
            rd_data <= mem[rd_addr];
        end
    end

endmodule

// File: rtl/pxu_rgb565_expand.sv
module pxu_rgb565_expand (
    input  logic [15:0] c16,
    output logic [23:0] c24
);
    logic [4:0] r5;
    logic [5:0] g6;
    logic [4:0] b5;

    always_comb begin
        r5  = c16[15:11];
        g6  = c16[10:5];
        b5  = c16[4:0];
        c24 = {r5, r5[4:2], g6, g6[5:4], b5, b5[4:2]};
    end

endmodule

// File: rtl/pxu_field_select.sv
module pxu_field_select
    import pxu_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int CNT_W  = 6
) (
    input  logic [DATA_W-1:0] word,
    input  depth_e            dep,
    input  order_e            ord,
    input  logic [CNT_W-1:0]  cnt,
    output logic [23:0]       field
);
    localparam int SH_W = $clog2(DATA_W) + 1;

    int           bpp;
    int           bo;
    int           sh;
    logic [SH_W-1:0] shift;
    logic [31:0]  shifted;
    logic [31:0]  mask;

    always_comb begin
        bpp = bpp_of(dep);
        bo  = int'(cnt) * bpp;
        sh  = 0;
        if (dep == DEP_24) begin
            if (ord == ORD_BE) begin
                sh = (cnt == '0) ? 24 : 0;
            end else begin
                sh = (cnt == '0) ? 0 : 24;
            end
        end else begin
            unique case (ord)
                ORD_BE: begin
                    sh = DATA_W - bpp - bo;
                end
                ORD_MIX: begin
                    if (bpp < 8) begin
                        sh = (bo & ~7) + 8 - bpp - (bo & 7);
                    end else begin
                        sh = bo;
                    end
                end
                ORD_LE, ORD_LE2: begin
                    sh = bo;
                end
            endcase
        end
        shift   = SH_W'(sh);
        shifted = 32'(word >> shift);
        mask    = (32'h1 << bpp) - 32'h1;
        field   = 24'(shifted & mask);
    end

endmodule

// File: rtl/lcd_pixel_unpacker.sv
module lcd_pixel_unpacker
    import pxu_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int PAL_AW = 7,
    parameter int PAL_DW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        cfg_depth,
    input  logic [1:0]        cfg_order,
    input  logic              cfg_tft,
    input  logic              pal_we,
    input  logic [PAL_AW-1:0] pal_waddr,
    input  logic [PAL_DW-1:0] pal_wdata,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    output logic              px_valid,
    input  logic              px_ready,
    output logic [23:0]       px_rgb,
    output logic              px_pal
);
    localparam int CNT_W  = $clog2(DATA_W);
    localparam int ENT_W  = PAL_DW / 2;

    // ---------------- state and datapath registers ----------------
    ust_e              state_q, state_d;
    logic [DATA_W-1:0] word_q;
    depth_e            dep_q;
    order_e            ord_q;
    logic [CNT_W-1:0]  cnt_q;

    logic              o_valid_q;
    logic              o_pal_q;
    logic              o_half_q;
    logic [23:0]       o_direct_q;

    // ---------------- control terms ----------------
    logic              advance;
    logic              accept;
    logic              issue;
    logic              last_pix;
    logic [CNT_W-1:0]  last_cnt;
    depth_e            dep_in;

    logic [23:0]       field;
    logic              is_pal;
    logic [7:0]        pal_idx;
    logic [23:0]       c16_direct;
    logic [23:0]       direct;
    logic [PAL_DW-1:0] pal_rd;
    logic [ENT_W-1:0]  pal_ent;
    logic [23:0]       c16_pal;

    // Depth decode at accept: 24 bpp needs a TFT panel, spare codes act as 8 bpp
    always_comb begin
        unique case (cfg_depth)
            3'd0:    dep_in = DEP_1;
            3'd1:    dep_in = DEP_2;
            3'd2:    dep_in = DEP_4;
            3'd3:    dep_in = DEP_8;
            3'd4:    dep_in = DEP_16;
            3'd5:    dep_in = cfg_tft ? DEP_24 : DEP_16;
            default: dep_in = DEP_8;
        endcase
    end

    always_comb begin
        advance  = !o_valid_q || px_ready;
        accept   = in_valid && (state_q == ST_IDLE);
        issue    = (state_q == ST_EMIT) && advance;
        last_cnt = CNT_W'(last_of(dep_q, DATA_W));
        last_pix = (cnt_q == last_cnt);
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept)              state_d = ST_EMIT;
            ST_EMIT: if (issue && last_pix)   state_d = ST_IDLE;
        endcase
    end

    // ---------------- FSM outputs ----------------
    always_comb begin
        in_ready = 1'b0;
        unique case (state_q)
            ST_IDLE: in_ready = 1'b1;
            ST_EMIT: in_ready = 1'b0;
        endcase
    end

    // ---------------- word holding and pixel counter ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
            dep_q  <= DEP_8;
            ord_q  <= ORD_LE;
            cnt_q  <= '0;
        end else if (accept) begin
            word_q <= in_data;
            dep_q  <= dep_in;
            ord_q  <= order_e'(cfg_order);
            cnt_q  <= '0;
        end else if (issue) begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    // ---------------- field extraction ----------------
    pxu_field_select #(
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W)
    ) u_sel (
        .word  (word_q),
        .dep   (dep_q),
        .ord   (ord_q),
        .cnt   (cnt_q),
        .field (field)
    );

    pxu_rgb565_expand u_exp_direct (
        .c16 (field[15:0]),
        .c24 (c16_direct)
    );

    always_comb begin
        is_pal  = (dep_q == DEP_1) || (dep_q == DEP_2) ||
                  (dep_q == DEP_4) || (dep_q == DEP_8);
        pal_idx = field[7:0];
        direct  = (dep_q == DEP_24) ? field : c16_direct;
    end

    // ---------------- color table ----------------
    pxu_palette_ram #(
        .AW (PAL_AW),
        .DW (PAL_DW)
    ) u_pal (
        .clk     (clk),
        .wr_en   (pal_we),
        .wr_addr (pal_waddr),
        .wr_data (pal_wdata),
        .rd_en   (issue && is_pal),
        .rd_addr (pal_idx[PAL_AW:1]),
        .rd_data (pal_rd)
    );

    // ---------------- output register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            o_valid_q  <= 1'b0;
            o_pal_q    <= 1'b0;
            o_half_q   <= 1'b0;
            o_direct_q <= '0;
        end else if (advance) begin
            o_valid_q <= issue;
            if (issue) begin
                o_pal_q    <= is_pal;
                o_half_q   <= pal_idx[0];
                o_direct_q <= direct;
            end
        end
    end

    always_comb begin
        pal_ent = o_half_q ? pal_rd[PAL_DW-1:ENT_W] : pal_rd[ENT_W-1:0];
    end

    pxu_rgb565_expand u_exp_pal (
        .c16 (pal_ent),
        .c24 (c16_pal)
    );

    always_comb begin
        px_valid = o_valid_q;
        px_pal   = o_pal_q;
        px_rgb   = o_pal_q ? c16_pal : o_direct_q;
    end

endmodule

// File: rtl/pxu_checker.sv
module pxu_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic        in_ready,
    input logic        px_valid,
    input logic        px_ready,
    input logic [23:0] px_rgb,
    input logic        px_pal
);

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        px_valid && !px_ready |=> px_valid && $stable(px_rgb) && $stable(px_pal)) else $error("stall hold"); // R9

    AST_ACCEPT_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> !in_ready) else $error("accept closes"); // R10

    AST_FIRST_PIXEL: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |-> ##2 px_valid) else $error("first pixel"); // R11

    AST_BUSY_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready && !px_valid |=> px_valid) else $error("busy fills"); // R11

    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |-> in_ready && !px_valid) else $error("reset idle"); // R1

endmodule

bind lcd_pixel_unpacker pxu_checker u_chk (.*);

// File: tb/lcd_pixel_unpacker_tb.sv
module lcd_pixel_unpacker_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cfg_depth = 3'd3;
    logic [1:0]  cfg_order = 2'd0;
    logic        cfg_tft = 1'b0;
    logic        pal_we = 1'b0;
    logic [6:0]  pal_waddr = '0;
    logic [31:0] pal_wdata = '0;
    logic        in_valid = 1'b0;
    logic [63:0] in_data = '0;
    logic        in_ready;
    logic        px_valid;
    logic        px_ready = 1'b1;
    logic [23:0] px_rgb;
    logic        px_pal;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;
    bit stall_mode = 1'b0;
    bit mon_on = 1'b0;

    logic [15:0] pal_m [256];
    logic [24:0] exp_q [$];
    string       tag_q [$];

    always #5 clk = ~clk;

    lcd_pixel_unpacker u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_depth(cfg_depth), .cfg_order(cfg_order),
        .cfg_tft(cfg_tft), .pal_we(pal_we), .pal_waddr(pal_waddr), .pal_wdata(pal_wdata),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .px_valid(px_valid), .px_ready(px_ready), .px_rgb(px_rgb), .px_pal(px_pal)
    );

    // ---------------- reference model ----------------
    function automatic logic [23:0] widen(logic [15:0] e);
        logic [7:0] r, g, b;
        r = {e[15:11], 3'b0} | {5'b0, e[15:13]};
        g = {e[10:5], 2'b0}  | {6'b0, e[10:9]};
        b = {e[4:0], 3'b0}   | {5'b0, e[4:2]};
        return {r, g, b};
    endfunction

    function automatic int eff_bpp(int dcode, bit tft);
        case (dcode)
            0: return 1;
            1: return 2;
            2: return 4;
            4: return 16;
            5: return tft ? 24 : 16;
            default: return 8;
        endcase
    endfunction

    function automatic int px_count(int dcode, bit tft);
        int b;
        b = eff_bpp(dcode, tft);
        return (b == 24) ? 2 : 64 / b;
    endfunction

    function automatic logic [24:0] model_px(logic [63:0] w, int dcode, int ord, bit tft, int i);
        int b, n, p, per, bb, k, pos;
        logic [15:0] f;
        b = eff_bpp(dcode, tft);
        if (b == 24) begin
            if (ord == 1) pos = (i == 0) ? 24 : 0;
            else          pos = (i == 0) ? 0 : 24;
            return {1'b0, w[pos +: 24]};
        end
        n = 64 / b;
        if (ord == 1) p = n - 1 - i;
        else if (ord == 2 && b < 8) begin
            per = 8 / b;
            bb = i / per;
            k = i % per;
            p = bb * per + (per - 1 - k);
        end else p = i;
        f = '0;
        for (int j = 0; j < b; j++) f[j] = w[p * b + j];
        if (b == 16) return {1'b0, widen(f)};
        return {1'b1, widen(pal_m[f[7:0]])};
    endfunction

    function automatic logic [15:0] ent_val(int e);
        return 16'((e * 40503 + 977) ^ (e << 9));
    endfunction

    // ---------------- ready driver ----------------
    initial begin
        logic [15:0] lfsr;
        lfsr = 16'hace1;
        forever begin
            @(posedge clk);
            #1;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            px_ready = stall_mode ? (lfsr[0] | lfsr[5]) : 1'b1;
        end
    end

    // ---------------- output monitor ----------------
    initial begin
        bit          prev_stall;
        logic [23:0] prev_rgb;
        logic        prev_pal;
        logic [24:0] e;
        string       t;
        prev_stall = 1'b0;
        prev_rgb = '0;
        prev_pal = 1'b0;
        forever begin
            @(negedge clk);
            if (mon_on) begin
                if (prev_stall) begin
                    n_cmp++;
                    if (!px_valid || px_rgb !== prev_rgb || px_pal !== prev_pal) begin
                        n_bad++;
                        $display("FAIL R9 stall hold: got v=%0b rgb=%h pal=%0b expected v=1 rgb=%h pal=%0b",
                                 px_valid, px_rgb, px_pal, prev_rgb, prev_pal);
                    end
                end
                if (in_ready && exp_q.size() > 1) begin
                    n_cmp++;
                    n_bad++;
                    $display("FAIL R10 in_ready high with %0d pixels pending, expected at most 1", exp_q.size());
                end
                if (px_valid && px_ready) begin
                    n_cmp++;
                    if (exp_q.size() == 0) begin
                        n_bad++;
                        $display("FAIL R3 extra pixel: got rgb=%h pal=%0b expected none", px_rgb, px_pal);
                    end else begin
                        e = exp_q.pop_front();
                        t = tag_q.pop_front();
                        if ({px_pal, px_rgb} !== e) begin
                            n_bad++;
                            $display("FAIL %s pixel: got pal=%0b rgb=%h expected pal=%0b rgb=%h",
                                     t, px_pal, px_rgb, e[24], e[23:0]);
                        end
                    end
                end
                prev_stall = px_valid && !px_ready;
                prev_rgb = px_rgb;
                prev_pal = px_pal;
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic check(bit ok, string tag, string what, int got, int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
        end
    endtask

    task automatic pal_write(int k, logic [31:0] d);
        @(posedge clk);
        #1;
        pal_we = 1'b1;
        pal_waddr = 7'(k);
        pal_wdata = d;
        @(posedge clk);
        #1;
        pal_we = 1'b0;
        pal_m[2 * k] = d[15:0];
        pal_m[2 * k + 1] = d[31:16];
    endtask

    task automatic send(logic [63:0] w, int dcode, int ord, bit tft, string tag);
        @(posedge clk);
        #1;
        in_valid = 1'b1;
        in_data = w;
        cfg_depth = 3'(dcode);
        cfg_order = 2'(ord);
        cfg_tft = tft;
        forever begin
            @(negedge clk);
            if (in_ready) break;
        end
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        in_data = ~w;
        for (int i = 0; i < px_count(dcode, tft); i++) begin
            exp_q.push_back(model_px(w, dcode, ord, tft, i));
            tag_q.push_back(tag);
        end
    endtask

    task automatic drain(string tag);
        int guard;
        guard = 0;
        while (exp_q.size() != 0 && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, tag, "pixels left", exp_q.size(), 0);
        check(px_valid == 1'b0 && in_ready == 1'b1, tag, "idle after word", int'(px_valid), 0);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        repeat (3) @(negedge clk);
        check(in_ready == 1'b1, "R1", "in_ready in reset", int'(in_ready), 1);
        check(px_valid == 1'b0, "R1", "px_valid in reset", int'(px_valid), 0);
        @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(negedge clk);
        check(in_ready == 1'b1 && px_valid == 1'b0, "R1", "idle after reset", int'(px_valid), 0);
        mon_on = 1'b1;
    endtask

    task automatic t_load_palette();
        for (int k = 0; k < 128; k++) pal_write(k, {ent_val(2 * k + 1), ent_val(2 * k)});
        send(64'h0706_0504_0302_0100, 3, 0, 1'b0, "R2");
        send(64'hff80_7f81_fe01_02fd, 3, 0, 1'b0, "R2");
        drain("R2");
    endtask

    task automatic t_pal8_orders();
        send(64'h1122_3344_5566_7788, 3, 0, 1'b0, "R4");
        send(64'h1122_3344_5566_7788, 3, 1, 1'b0, "R5");
        send(64'h1122_3344_5566_7788, 3, 2, 1'b0, "R6");
        send(64'h9abc_def0_1357_9bdf, 7, 0, 1'b0, "R3");
        drain("R4");
    endtask

    task automatic t_small_depths();
        send(64'hc3a5_0f96_7e81_1ee7, 0, 0, 1'b0, "R4");
        send(64'hc3a5_0f96_7e81_1ee7, 0, 2, 1'b0, "R6");
        send(64'h1b2d_e4c9_8765_4321, 1, 1, 1'b0, "R5");
        send(64'h1b2d_e4c9_8765_4321, 1, 2, 1'b0, "R6");
        send(64'hfedc_ba98_7654_3210, 2, 0, 1'b0, "R4");
        send(64'hfedc_ba98_7654_3210, 2, 2, 1'b0, "R6");
        send(64'hfedc_ba98_7654_3210, 2, 3, 1'b0, "R3");
        drain("R6");
    endtask

    task automatic t_true16();
        send(64'hf800_07e0_001f_8410, 4, 0, 1'b0, "R7");
        send(64'hf800_07e0_001f_8410, 4, 1, 1'b0, "R7");
        send(64'h1234_ffff_0000_a5a5, 4, 2, 1'b1, "R7");
        drain("R7");
    endtask

    task automatic t_true24();
        send(64'hdead_1234_56ab_cdef, 5, 0, 1'b1, "R8");
        send(64'hbeef_1234_56ab_cdef, 5, 1, 1'b1, "R8");
        send(64'h0000_8040_2010_0804, 5, 2, 1'b1, "R8");
        send(64'hdead_1234_56ab_cdef, 5, 0, 1'b0, "R8");
        drain("R8");
    endtask

    task automatic t_stall();
        stall_mode = 1'b1;
        send(64'h0123_4567_89ab_cdef, 3, 1, 1'b0, "R9");
        send(64'h0123_4567_89ab_cdef, 1, 2, 1'b0, "R9");
        send(64'h0123_4567_89ab_cdef, 4, 0, 1'b0, "R9");
        send(64'hffff_0123_4567_89ab, 5, 1, 1'b1, "R9");
        send(64'h5555_aaaa_3333_cccc, 0, 1, 1'b0, "R9");
        drain("R9");
        stall_mode = 1'b0;
    endtask

    task automatic t_cfg_latch();
        send(64'h2468_ace0_1357_9bdf, 2, 0, 1'b0, "R10");
        @(posedge clk);
        #1;
        cfg_depth = 3'd4;
        cfg_order = 2'd1;
        cfg_tft = 1'b1;
        drain("R10");
    endtask

    task automatic t_pal_rewrite();
        pal_write(3, 32'h07e0_f800);
        send(64'h0000_0000_0000_0706, 3, 0, 1'b0, "R2");
        drain("R2");
        check(pal_m[7] == 16'h07e0, "R2", "model high half", int'(pal_m[7]), 16'h07e0);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R11 watchdog: pending %0d expected 0", exp_q.size());
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    // ---------------- main ----------------
    initial begin
        for (int e = 0; e < 256; e++) pal_m[e] = '0;
        t_reset();
        t_load_palette();
        t_pal8_orders();
        t_small_depths();
        t_true16();
        t_true24();
        t_stall();
        t_cfg_latch();
        t_pal_rewrite();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule